// File: doc/BRIEF.md
# Physical Register File with Same-Cycle Result Bypass

This block holds the renamed register state of an out-of-order core and supplies operands to the issue stage. Every execution unit that finishes an instruction drives one result bus with a valid flag, the destination physical register number and the result. The result is written into its physical register at the end of that cycle. No separate architectural copy exists. The stored array is treated as unable to return a value in the cycle it is written. Each source operand therefore compares its physical register number against every live result bus. On a match it takes the bus value, and otherwise it takes the stored value.

A ready flag per physical register records whether the register holds its final data. The rename stage clears the flag when it hands out a register as a new destination. A result broadcast sets it again. Because the broadcast counts as ready in the cycle it appears, a consumer can issue in the cycle right after its one-cycle producer and still get the fresh value. Each issue port reports one "may issue" flag that covers both of its sources. Physical register zero is a hard-wired zero.

Top module: `prf_bypass_file`

## Requirements
- R1: After reset every physical register reads as zero and is ready, so every issue port reports that it may issue.
- R2: A result on a valid bus with a nonzero tag is stored in that register at the clock edge. From the next cycle on, a read of that tag with no matching bus returns the stored value until a later result overwrites it.
- R3: A source whose tag matches a valid result bus in the same cycle returns that bus's value, not the older stored value. This also covers a consumer that issues in the cycle after its producer while the producer's result is on a bus.
- R4: An allocation of a nonzero tag clears that register's ready flag from the next cycle on, and the flag stays clear until a result for that tag is broadcast. An allocation and a broadcast of the same nonzero tag in one cycle is a usage error and is flagged.
- R5: A valid broadcast of a nonzero tag makes that register count as ready in the same cycle, and the ready flag stays set in the following cycles.
- R6: An issue port's may-issue output is 1 exactly when both of its sources are ready, either by the stored flag or by a same-cycle broadcast.
- R7: Tag 0 always reads as zero and is always ready. Broadcasts and allocations that name tag 0 have no effect.
- R8: Two valid buses with distinct nonzero tags write and bypass independently in the same cycle. Two valid buses that carry the same nonzero tag in one cycle is a usage error and is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_valid | input | NUM_WB | Result bus valid, one bit per bus |
| wb_tag | input | NUM_WB x TAG_W | Destination physical register per bus |
| wb_data | input | NUM_WB x DATA_W | Result value per bus |
| al_valid | input | NUM_ALLOC | Destination allocation valid per rename slot |
| al_tag | input | NUM_ALLOC x TAG_W | Physical register being handed out |
| rd_tag | input | NUM_RD x 2 x TAG_W | Source physical registers per issue port |
| rd_data | output | NUM_RD x 2 x DATA_W | Source operand values per issue port |
| rd_ok | output | NUM_RD | Issue port may issue: both sources ready |

## Verification
The embedded properties check on every cycle that a matching bus overrides the stored value, that tag 0 returns zero and reports ready, that each written value appears in its register one edge later, and that allocation and broadcast move the ready flags in the right direction. They also reject duplicate tags across buses and an allocation that collides with a broadcast. Only the bench scenarios show the sequences around these rules. One is the back-to-back producer and consumer that must see the new value and not the older one. Others are a port held back by one pending source while the other source is bypassed, and stored values that survive many unrelated writes.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned DEF_NUM_WB    = 2;
  localparam int unsigned DEF_NUM_ALLOC = 2;
  localparam int unsigned DEF_NUM_RD    = 2;
  localparam int unsigned SRC_PER_PORT  = 2;
  localparam int unsigned DEF_TAG_W     = 6;
  localparam int unsigned DEF_DATA_W    = 32;

  function automatic int unsigned regs_for(input int unsigned tag_w);
    return 1 << tag_w;
  endfunction
endpackage

// File: rtl/prf_ready_table.sv
module prf_ready_table #(
  parameter int unsigned NUM_WB    = prf_pkg::DEF_NUM_WB,
  parameter int unsigned NUM_ALLOC = prf_pkg::DEF_NUM_ALLOC,
  parameter int unsigned TAG_W     = prf_pkg::DEF_TAG_W,
  localparam int unsigned NUM_REGS = prf_pkg::regs_for(TAG_W)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_WB-1:0]                  wb_valid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]       wb_tag,
  input  logic [NUM_ALLOC-1:0]               al_valid,
  input  logic [NUM_ALLOC-1:0][TAG_W-1:0]    al_tag,
  output logic [NUM_REGS-1:0]                rdy_now
);
  logic [NUM_REGS-1:0] rdy_q;
  logic [NUM_REGS-1:0] rdy_d;
  logic [NUM_REGS-1:0] bc_hit;
  logic [NUM_REGS-1:0] al_hit;
  logic [NUM_REGS-1:0] rdy_en;

  // decode broadcasts and allocations into one-hot-per-source vectors
  always_comb begin
    bc_hit = '0;
    al_hit = '0;
    for (int b = 0; b < int'(NUM_WB); b++) begin
      if (wb_valid[b]) bc_hit[wb_tag[b]] = 1'b1;
    end
    for (int a = 0; a < int'(NUM_ALLOC); a++) begin
      if (al_valid[a]) al_hit[al_tag[a]] = 1'b1;
    end
    bc_hit[0] = 1'b0;
    al_hit[0] = 1'b0;
  end

  // next state and clock enable per flag
  always_comb begin
    rdy_d    = (rdy_q & ~al_hit) | bc_hit;
    rdy_d[0] = 1'b1;
    rdy_en   = al_hit | bc_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '1;
    end else begin
      for (int p = 0; p < int'(NUM_REGS); p++) begin
        if (rdy_en[p]) rdy_q[p] <= rdy_d[p];
      end
    end
  end

  // a same-cycle broadcast already counts as ready
  always_comb begin
    rdy_now    = rdy_q | bc_hit;
    rdy_now[0] = 1'b1;
  end

  assert_zero_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_now[0]);

  for (genvar b = 0; b < NUM_WB; b++) begin : g_bc_chk
    assert_bc_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid[b] && wb_tag[b] != '0) |=> rdy_q[$past(wb_tag[b])]);
    for (genvar a = 0; a < NUM_ALLOC; a++) begin : g_col
      assert_alloc_bc_collide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid[b] && al_valid[a] && wb_tag[b] == al_tag[a] && al_tag[a] != '0));
    end
  end

  for (genvar a = 0; a < NUM_ALLOC; a++) begin : g_al_chk
    assert_alloc_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (al_valid[a] && al_tag[a] != '0) |=> !rdy_q[$past(al_tag[a])]);
  end
endmodule

// File: rtl/prf_storage.sv
module prf_storage #(
  parameter int unsigned NUM_WB   = prf_pkg::DEF_NUM_WB,
  parameter int unsigned NUM_SRC  = 4,
  parameter int unsigned TAG_W    = prf_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W   = prf_pkg::DEF_DATA_W,
  localparam int unsigned NUM_REGS = prf_pkg::regs_for(TAG_W)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WB-1:0]                 wb_valid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]      wb_tag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]     wb_data,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]     rf_addr,
  output logic [NUM_SRC-1:0][DATA_W-1:0]    rf_data
);
  logic [DATA_W-1:0]   mem_q [NUM_REGS];
  logic [DATA_W-1:0]   wd    [NUM_REGS];
  logic [NUM_REGS-1:0] we;

  // one write port per bus; lower bus index takes precedence
  always_comb begin
    we = '0;
    for (int p = 0; p < int'(NUM_REGS); p++) wd[p] = '0;
    for (int b = int'(NUM_WB) - 1; b >= 0; b--) begin
      if (wb_valid[b] && wb_tag[b] != '0) begin
        we[wb_tag[b]] = 1'b1;
        wd[wb_tag[b]] = wb_data[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < int'(NUM_REGS); p++) mem_q[p] <= '0;
    end else begin
      for (int p = 0; p < int'(NUM_REGS); p++) begin
        if (we[p]) mem_q[p] <= wd[p];
      end
    end
  end

  // read returns the value before this cycle's writes
  always_comb begin
    for (int s = 0; s < int'(NUM_SRC); s++) rf_data[s] = mem_q[rf_addr[s]];
  end

  for (genvar b = 0; b < NUM_WB; b++) begin : g_wr_chk
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid[b] && wb_tag[b] != '0) |=> mem_q[$past(wb_tag[b])] == $past(wb_data[b]));
    for (genvar c = b + 1; c < NUM_WB; c++) begin : g_dup
      assert_no_dup_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid[b] && wb_valid[c] && wb_tag[b] == wb_tag[c] && wb_tag[b] != '0));
    end
  end
endmodule

// File: rtl/prf_operand_mux.sv
module prf_operand_mux #(
  parameter int unsigned NUM_WB = prf_pkg::DEF_NUM_WB,
  parameter int unsigned TAG_W  = prf_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = prf_pkg::DEF_DATA_W
) (
  input  logic [TAG_W-1:0]                  src_tag,
  input  logic [NUM_WB-1:0]                 wb_valid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]      wb_tag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]     wb_data,
  input  logic [DATA_W-1:0]                 rf_data,
  output logic [DATA_W-1:0]                 opnd
);
  logic [NUM_WB-1:0] match;

  always_comb begin
    for (int b = 0; b < int'(NUM_WB); b++) match[b] = wb_valid[b] && (wb_tag[b] == src_tag);
  end

  always_comb begin
    opnd = rf_data;
    for (int b = int'(NUM_WB) - 1; b >= 0; b--) begin
      if (match[b]) opnd = wb_data[b];
    end
    if (src_tag == '0) opnd = '0;
  end
endmodule

// File: rtl/prf_bypass_file.sv
module prf_bypass_file #(
  parameter int unsigned NUM_WB    = prf_pkg::DEF_NUM_WB,
  parameter int unsigned NUM_ALLOC = prf_pkg::DEF_NUM_ALLOC,
  parameter int unsigned NUM_RD    = prf_pkg::DEF_NUM_RD,
  parameter int unsigned TAG_W     = prf_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W    = prf_pkg::DEF_DATA_W
) (
  input  logic                                                     clk,
  input  logic                                                     rst_n,
  input  logic [NUM_WB-1:0]                                        wb_valid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]                             wb_tag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]                            wb_data,
  input  logic [NUM_ALLOC-1:0]                                     al_valid,
  input  logic [NUM_ALLOC-1:0][TAG_W-1:0]                          al_tag,
  input  logic [NUM_RD-1:0][prf_pkg::SRC_PER_PORT-1:0][TAG_W-1:0]  rd_tag,
  output logic [NUM_RD-1:0][prf_pkg::SRC_PER_PORT-1:0][DATA_W-1:0] rd_data,
  output logic [NUM_RD-1:0]                                        rd_ok
);
  localparam int unsigned NSP      = prf_pkg::SRC_PER_PORT;
  localparam int unsigned NSRC     = NUM_RD * NSP;
  localparam int unsigned NUM_REGS = prf_pkg::regs_for(TAG_W);

  logic [NSRC-1:0][TAG_W-1:0]  src_tag;
  logic [NSRC-1:0][DATA_W-1:0] rf_data;
  logic [NSRC-1:0][DATA_W-1:0] opnd;
  logic [NUM_REGS-1:0]         rdy_now;

  prf_ready_table #(.NUM_WB(NUM_WB), .NUM_ALLOC(NUM_ALLOC), .TAG_W(TAG_W)) u_rdy (
    .clk(clk), .rst_n(rst_n),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .al_valid(al_valid), .al_tag(al_tag),
    .rdy_now(rdy_now)
  );

  prf_storage #(.NUM_WB(NUM_WB), .NUM_SRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .rf_addr(src_tag), .rf_data(rf_data)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_port
    for (genvar i = 0; i < NSP; i++) begin : g_src
      localparam int unsigned S = r * NSP + i;
      assign src_tag[S]    = rd_tag[r][i];
      assign rd_data[r][i] = opnd[S];

      prf_operand_mux #(.NUM_WB(NUM_WB), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_mux (
        .src_tag(src_tag[S]), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .wb_data(wb_data), .rf_data(rf_data[S]), .opnd(opnd[S])
      );

      assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_tag[r][i] == '0) |-> (rd_data[r][i] == '0));
      for (genvar b = 0; b < NUM_WB; b++) begin : g_byp_chk
        assert_bypass_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (wb_valid[b] && wb_tag[b] == rd_tag[r][i] && rd_tag[r][i] != '0)
            |-> (rd_data[r][i] == wb_data[b]));
      end
    end
  end

  always_comb begin
    for (int r = 0; r < int'(NUM_RD); r++) begin
      rd_ok[r] = 1'b1;
      for (int i = 0; i < int'(NSP); i++) rd_ok[r] = rd_ok[r] & rdy_now[rd_tag[r][i]];
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_ok_chk
    assert_ok_needs_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_tag[r][0] == '0 && rd_tag[r][1] == '0) |-> rd_ok[r]);
  end
endmodule

// File: tb/sim_prf_bypass_file.sv
`timescale 1ns/1ps
module sim_prf_bypass_file;
  localparam int NWB = 2, NAL = 2, NRD = 2, NSP = 2, TW = 6, DW = 32;
  localparam int NREG = 1 << TW;
  localparam real HALF = 2.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NWB-1:0]                 wb_valid;
  logic [NWB-1:0][TW-1:0]         wb_tag;
  logic [NWB-1:0][DW-1:0]         wb_data;
  logic [NAL-1:0]                 al_valid;
  logic [NAL-1:0][TW-1:0]         al_tag;
  logic [NRD-1:0][NSP-1:0][TW-1:0] rd_tag;
  logic [NRD-1:0][NSP-1:0][DW-1:0] rd_data;
  logic [NRD-1:0]                 rd_ok;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] m_val [NREG];
  logic          m_rdy [NREG];

  always #(HALF) clk = ~clk;

  prf_bypass_file u0 (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .al_valid(al_valid), .al_tag(al_tag), .rd_tag(rd_tag), .rd_data(rd_data), .rd_ok(rd_ok)
  );

  function automatic logic [DW-1:0] exp_val(input logic [TW-1:0] t);
    if (t == '0) return '0;
    for (int b = 0; b < NWB; b++) if (wb_valid[b] && wb_tag[b] == t) return wb_data[b];
    return m_val[t];
  endfunction

  function automatic logic exp_rdy(input logic [TW-1:0] t);
    if (t == '0) return 1'b1;
    for (int b = 0; b < NWB; b++) if (wb_valid[b] && wb_tag[b] == t) return 1'b1;
    return m_rdy[t];
  endfunction

  function automatic string data_req(input logic [TW-1:0] t);
    if (t == '0) return "R7";
    if (wb_valid[1] && wb_tag[1] == t) return "R8";
    if (wb_valid[0] && wb_tag[0] == t) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string req, input string ctx, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, ctx, act, exp);
    end
  endtask

  task automatic clear_in();
    wb_valid = '0; wb_tag = '0; wb_data = '0;
    al_valid = '0; al_tag = '0; rd_tag = '0;
  endtask

  // called right after the inputs are driven at a falling edge
  task automatic check_and_update(input string ctx);
    #1;
    for (int r = 0; r < NRD; r++) begin
      logic ok_e;
      ok_e = 1'b1;
      for (int i = 0; i < NSP; i++) begin
        chk(data_req(rd_tag[r][i]), ctx, rd_data[r][i], exp_val(rd_tag[r][i]));
        ok_e = ok_e & exp_rdy(rd_tag[r][i]);
      end
      chk("R6", ctx, {31'd0, rd_ok[r]}, {31'd0, ok_e});
    end
    for (int a = 0; a < NAL; a++) if (al_valid[a] && al_tag[a] != '0) m_rdy[al_tag[a]] = 1'b0;
    for (int b = NWB - 1; b >= 0; b--) begin
      if (wb_valid[b] && wb_tag[b] != '0) begin
        m_rdy[wb_tag[b]] = 1'b1;
        m_val[wb_tag[b]] = wb_data[b];
      end
    end
  endtask

  function automatic logic [TW-1:0] rnd_tag();
    if ($urandom % 2 == 0) return TW'($urandom % 8);
    return TW'($urandom);
  endfunction

  initial begin : watchdog
    #(4.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    for (int p = 0; p < NREG; p++) begin m_val[p] = '0; m_rdy[p] = 1'b1; end
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: state right after reset
    @(negedge clk); clear_in();
    rd_tag[0][0] = 6'd1; rd_tag[0][1] = 6'd37; rd_tag[1][0] = 6'd63; rd_tag[1][1] = 6'd0;
    check_and_update("R1 reset state");

    // R4: allocate 5 and 9, still ready this cycle
    @(negedge clk); clear_in();
    al_valid = 2'b11; al_tag[0] = 6'd5; al_tag[1] = 6'd9;
    rd_tag[0][0] = 6'd5; rd_tag[0][1] = 6'd9;
    check_and_update("R4 allocate");

    // R4 R6: both pending, one pending
    @(negedge clk); clear_in();
    rd_tag[0][0] = 6'd5; rd_tag[0][1] = 6'd9; rd_tag[1][0] = 6'd5; rd_tag[1][1] = 6'd0;
    check_and_update("R4 pending");
    chk("R4", "pending port", {31'd0, rd_ok[1]}, 32'd0);

    // R5 R6: broadcast 5, port0 still waits on 9
    @(negedge clk); clear_in();
    wb_valid[0] = 1'b1; wb_tag[0] = 6'd5; wb_data[0] = 32'hA5A5_0001;
    rd_tag[0][0] = 6'd5; rd_tag[0][1] = 6'd9; rd_tag[1][0] = 6'd5; rd_tag[1][1] = 6'd0;
    check_and_update("R5 same-cycle ready");
    chk("R5", "ready via broadcast", {31'd0, rd_ok[1]}, 32'd1);

    // R8: two buses at once, R2 stored 5
    @(negedge clk); clear_in();
    wb_valid = 2'b11; wb_tag[0] = 6'd12; wb_data[0] = 32'h0000_0C0C;
    wb_tag[1] = 6'd9; wb_data[1] = 32'h1234_5678;
    rd_tag[0][0] = 6'd5; rd_tag[0][1] = 6'd9; rd_tag[1][0] = 6'd9; rd_tag[1][1] = 6'd12;
    check_and_update("R8 dual bus");
    chk("R2", "stored after write", rd_data[0][0], 32'hA5A5_0001);

    // R3: back-to-back producer/consumer on tag 20
    @(negedge clk); clear_in();
    wb_valid[0] = 1'b1; wb_tag[0] = 6'd20; wb_data[0] = 32'd111;
    check_and_update("R3 first value");
    @(negedge clk); clear_in();
    al_valid[0] = 1'b1; al_tag[0] = 6'd20;
    check_and_update("R3 realloc");
    @(negedge clk); clear_in();
    wb_valid[1] = 1'b1; wb_tag[1] = 6'd20; wb_data[1] = 32'd222;
    rd_tag[1][1] = 6'd20;
    check_and_update("R3 back-to-back");
    chk("R3", "consumer sees new value", rd_data[1][1], 32'd222);
    @(negedge clk); clear_in();
    rd_tag[0][1] = 6'd20;
    check_and_update("R2 read after bypass");

    // R7: tag 0 ignores broadcast and allocation
    @(negedge clk); clear_in();
    wb_valid[0] = 1'b1; wb_tag[0] = 6'd0; wb_data[0] = 32'hFFFF_FFFF;
    al_valid[0] = 1'b1; al_tag[0] = 6'd0; rd_tag[0][0] = 6'd0;
    check_and_update("R7 write zero");
    @(negedge clk); clear_in();
    rd_tag[0][0] = 6'd0; rd_tag[1][0] = 6'd0;
    check_and_update("R7 after write");
    chk("R7", "tag 0 ready", {31'd0, rd_ok[1]}, 32'd1);

    // random traffic under the usage rules
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); clear_in();
      for (int b = 0; b < NWB; b++) begin
        wb_valid[b] = ($urandom % 3) != 0; wb_tag[b] = rnd_tag(); wb_data[b] = $urandom;
      end
      if (wb_tag[1] == wb_tag[0]) wb_valid[1] = 1'b0;
      for (int a = 0; a < NAL; a++) begin
        al_valid[a] = ($urandom % 4) == 0; al_tag[a] = rnd_tag();
        for (int b = 0; b < NWB; b++) if (wb_valid[b] && wb_tag[b] == al_tag[a]) al_valid[a] = 1'b0;
      end
      for (int r = 0; r < NRD; r++) for (int i = 0; i < NSP; i++) rd_tag[r][i] = rnd_tag();
      check_and_update("random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule